// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block gathers exception reports from the fetch, decode, execute and memory stages of an in-order pipeline, and asynchronous interrupt requests from outside. It turns them into precise traps. It keeps a small tag for every instruction in flight. The tag holds a valid bit, a pending-exception bit, a cause code and the PC. The tags advance one stage per clock, alongside the instructions that the datapath itself moves.

Nothing is acted on until an instruction reaches the memory stage, which is the commit point. There, one decision is made for the cycle:
- an enabled interrupt wins over everything;
- otherwise the earliest-raised exception of the committing instruction is taken;
- otherwise the instruction commits normally.

A trap latches the cause and the exception PC and clears the interrupt enable. It flushes the younger stages, blocks the committing instruction's writeback, and steers fetch to a fixed handler address. A return request steers fetch back to the saved exception PC and enables interrupts again.

The instruction stream enters through a valid qualifier only. The pipeline seen by this block never stalls, so there is no ready signal and no back-pressure: a fetched instruction is accepted on every edge. The per-stage fault flags, the interrupt request and the return request are plain level inputs sampled on each rising edge.

Top module: `ptrap_ctrl`

## Requirements
- R1: An instruction fetched with `if_valid` high in cycle t holds the decode, execute and memory stages in cycles t+1, t+2 and t+3. Its fault flags are sampled only in those cycles (`if_fault` in t, `id_illegal` in t+1, `ex_overflow` in t+2, `mem_fault` in t+3). Any resulting synchronous trap is signalled on `trap_take` in cycle t+3 and never earlier.
- R2: When one instruction carries several faults, the earliest stage decides the cause. The codes on `cause_q` are: 1 for a fetch address fault, 2 for an illegal opcode, 3 for an overflow, 4 for a data address fault.
- R3: An interrupt is taken in any cycle where `irq` is high and `ie_q` is 1, whether or not an instruction is at commit. It takes priority over a synchronous exception in the same cycle, and it writes cause 0. While `ie_q` is 0, `irq` is ignored.
- R4: In a trap cycle, `trap_take`, `flush` and `redirect_valid` are high and `redirect_pc` equals the handler address. `cause_q` and `epc_q` show the new values after the next rising edge.
- R5: `epc_q` receives the PC of the committing instruction. For an interrupt with no valid instruction at commit, it receives the PC of the oldest valid instruction in flight, or `if_pc` if none is valid.
- R6: A bubble, meaning a slot whose instruction is not valid, never causes a synchronous trap, whatever its fault flags show.
- R7: A trap clears `ie_q`. When `trap_ret` is high and no trap is taken, `ie_q` is set, `flush` and `redirect_valid` rise, and `redirect_pc` equals `epc_q`. A trap in the same cycle wins over the return.
- R8: `commit_valid` is high with `commit_pc` equal to the instruction's PC exactly when a valid instruction is at commit and no trap is taken. Instructions flushed by a trap or a return never commit.
- R9: After reset, `ie_q` is 1, `cause_q` is 0, `epc_q` is 0 and no stage holds a valid instruction.
- R10: `cause_q` and `epc_q` keep their values in every cycle without a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | A real instruction is in fetch this cycle |
| if_pc | input | PCW | PC of the instruction in fetch |
| if_fault | input | 1 | Address fault on the fetch of the instruction in fetch |
| id_illegal | input | 1 | Illegal opcode for the instruction in decode |
| ex_overflow | input | 1 | Arithmetic overflow for the instruction in execute |
| mem_fault | input | 1 | Data address fault for the instruction in memory |
| irq | input | 1 | Asynchronous interrupt request, level |
| trap_ret | input | 1 | Return-from-trap request at commit |
| trap_take | output | 1 | A trap is taken this cycle |
| flush | output | 1 | Kill fetch, decode and execute contents |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | PCW | Handler address on trap, saved EPC on return |
| commit_valid | output | 1 | The memory-stage instruction may write back |
| commit_pc | output | PCW | PC of the memory-stage instruction |
| cause_q | output | 4 | Latched trap cause |
| epc_q | output | PCW | Latched exception PC |
| ie_q | output | 1 | Interrupt enable |

## Verification
The trap decision, `flush`, the redirect and `commit_valid` are combinational in the commit cycle, three edges after the instruction was fetched. `cause_q`, `epc_q` and `ie_q` change one edge after that decision. The bench drives each cycle's inputs on the falling edge and compares the combinational outputs 1 ns later, against a queue model of the instructions in flight. It compares the registered outputs in that same window against the values its model stored at the previous decision. This places each check in the cycle its result is due. Stimulus phases vary instruction density, fault rates, interrupt load and return frequency, so that the following cases all occur:
- several faults on one instruction;
- interrupts over bubbles;
- returns that collide with traps.

// File: rtl/ptrap_pkg.sv
package ptrap_pkg;

  localparam int NUM_STAGES = 4;
  localparam int CAUSE_W    = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ     = 4'd0,
    CAUSE_IFAULT  = 4'd1,
    CAUSE_ILLEGAL = 4'd2,
    CAUSE_OVF     = 4'd3,
    CAUSE_DFAULT  = 4'd4
  } cause_e;

  typedef struct packed {
    logic   valid;
    logic   exc;
    cause_e cause;
  } tag_t;

  localparam tag_t TAG_NONE = '{valid: 1'b0, exc: 1'b0, cause: CAUSE_IRQ};

  // First fault seen on a valid instruction sticks; later ones are dropped.
  function automatic tag_t tag_merge(tag_t t, logic flag, cause_e code);
    tag_t r;
    r = t;
    if (t.valid && flag && !t.exc) begin
      r.exc   = 1'b1;
      r.cause = code;
    end
    return r;
  endfunction

endpackage

// File: rtl/ptrap_exc_pipe.sv
module ptrap_exc_pipe
  import ptrap_pkg::*;
#(
  parameter int PCW = 32,
  parameter int NST = NUM_STAGES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    f_valid,
  input  logic [PCW-1:0]          f_pc,
  input  logic [NST-1:0]          flags,
  output tag_t                    c_tag,
  output logic [NST-1:0]          slot_valid,
  output logic [NST-1:0][PCW-1:0] slot_pc
);

  tag_t           tag_in [NST];
  tag_t           tag_m  [NST];
  tag_t           tag_q  [1:NST-1];
  logic [PCW-1:0] pc_q   [1:NST-1];

  always_comb begin
    tag_in[0]  = '{valid: f_valid, exc: 1'b0, cause: CAUSE_IRQ};
    slot_pc[0] = f_pc;
    for (int k = 1; k < NST; k++) begin
      tag_in[k]  = tag_q[k];
      slot_pc[k] = pc_q[k];
    end
  end

  // Stage g reports the fault with code g+1; merging in stage order makes
  // the earliest stage win for a given instruction.
  genvar g;
  generate
    for (g = 0; g < NST; g++) begin : g_slot
      assign tag_m[g]      = tag_merge(tag_in[g], flags[g], cause_e'(4'(g + 1)));
      assign slot_valid[g] = tag_in[g].valid;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 1; k < NST; k++) begin
        tag_q[k] <= TAG_NONE;
        pc_q[k]  <= '0;
      end
    end else begin
      for (int k = 1; k < NST; k++) begin
        tag_q[k] <= flush ? TAG_NONE : tag_m[k-1];
        pc_q[k]  <= slot_pc[k-1];
      end
    end
  end

  assign c_tag = tag_m[NST-1];

endmodule

// File: rtl/ptrap_commit_sel.sv
module ptrap_commit_sel
  import ptrap_pkg::*;
#(
  parameter int PCW = 32,
  parameter int NST = NUM_STAGES
) (
  input  logic                    irq,
  input  logic                    ie,
  input  tag_t                    c_tag,
  input  logic [NST-1:0]          slot_valid,
  input  logic [NST-1:0][PCW-1:0] slot_pc,
  output logic                    trap,
  output cause_e                  cause,
  output logic [PCW-1:0]          epc_next
);

  logic irq_take;
  logic sync_take;

  always_comb begin
    irq_take  = irq & ie;
    sync_take = c_tag.valid & c_tag.exc;
    trap      = irq_take | sync_take;
    cause     = irq_take ? CAUSE_IRQ : c_tag.cause;
    // Oldest valid slot wins; fetch PC when the pipe is empty.
    epc_next  = slot_pc[0];
    for (int k = 0; k < NST; k++) begin
      if (slot_valid[k]) epc_next = slot_pc[k];
    end
  end

endmodule

// File: rtl/ptrap_csr.sv
module ptrap_csr
  import ptrap_pkg::*;
#(
  parameter int             PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap,
  input  cause_e         cause,
  input  logic [PCW-1:0] epc_next,
  input  logic           ret_req,
  output cause_e         cause_q,
  output logic [PCW-1:0] epc_q,
  output logic           ie_q,
  output logic           flush,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_pc
);

  logic ret_take;

  assign ret_take       = ret_req & ~trap;
  assign flush          = trap | ret_take;
  assign redirect_valid = flush;
  assign redirect_pc    = trap ? HANDLER_PC : epc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= CAUSE_IRQ;
      epc_q   <= '0;
      ie_q    <= 1'b1;
    end else if (trap) begin
      cause_q <= cause;
      epc_q   <= epc_next;
      ie_q    <= 1'b0;
    end else if (ret_take) begin
      ie_q    <= 1'b1;
    end
  end

endmodule

// File: rtl/ptrap_ctrl.sv
module ptrap_ctrl
  import ptrap_pkg::*;
#(
  parameter int             PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           if_valid,
  input  logic [PCW-1:0] if_pc,
  input  logic           if_fault,
  input  logic           id_illegal,
  input  logic           ex_overflow,
  input  logic           mem_fault,
  input  logic           irq,
  input  logic           trap_ret,
  output logic           trap_take,
  output logic           flush,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_pc,
  output logic           commit_valid,
  output logic [PCW-1:0] commit_pc,
  output logic [3:0]     cause_q,
  output logic [PCW-1:0] epc_q,
  output logic           ie_q
);

  localparam int NST = NUM_STAGES;

  tag_t                    c_tag;
  logic [NST-1:0]          slot_valid;
  logic [NST-1:0][PCW-1:0] slot_pc;
  logic [NST-1:0]          flags;
  logic                    trap;
  cause_e                  cause;
  cause_e                  cause_r;
  logic [PCW-1:0]          epc_next;

  assign flags = {mem_fault, ex_overflow, id_illegal, if_fault};

  ptrap_exc_pipe #(.PCW(PCW), .NST(NST)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .f_valid    (if_valid),
    .f_pc       (if_pc),
    .flags      (flags),
    .c_tag      (c_tag),
    .slot_valid (slot_valid),
    .slot_pc    (slot_pc)
  );

  ptrap_commit_sel #(.PCW(PCW), .NST(NST)) u_sel (
    .irq        (irq),
    .ie         (ie_q),
    .c_tag      (c_tag),
    .slot_valid (slot_valid),
    .slot_pc    (slot_pc),
    .trap       (trap),
    .cause      (cause),
    .epc_next   (epc_next)
  );

  ptrap_csr #(.PCW(PCW), .HANDLER_PC(HANDLER_PC)) u_csr (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap           (trap),
    .cause          (cause),
    .epc_next       (epc_next),
    .ret_req        (trap_ret),
    .cause_q        (cause_r),
    .epc_q          (epc_q),
    .ie_q           (ie_q),
    .flush          (flush),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  assign trap_take    = trap;
  assign commit_valid = slot_valid[NST-1] & ~trap;
  assign commit_pc    = slot_pc[NST-1];
  assign cause_q      = cause_r;

endmodule

// File: rtl/ptrap_ctrl_chk.sv
module ptrap_ctrl_chk #(
  parameter int             PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = '0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input logic           trap_ret,
  input logic           trap_take,
  input logic           flush,
  input logic           redirect_valid,
  input logic [PCW-1:0] redirect_pc,
  input logic           commit_valid,
  input logic [3:0]     cause_q,
  input logic [PCW-1:0] epc_q,
  input logic           ie_q
);

  p_trap_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> (flush && redirect_valid && redirect_pc == HANDLER_PC && !commit_valid));

  p_ie_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !ie_q);

  p_ret_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !trap_take) |=> ie_q);

  p_cause_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (cause_q <= 4'd4));

  p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && irq && ie_q) |=> (cause_q == 4'd0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_take |=> ($stable(cause_q) && $stable(epc_q)));

  p_flush_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !commit_valid);

endmodule

bind ptrap_ctrl ptrap_ctrl_chk #(.PCW(PCW), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq            (irq),
  .trap_ret       (trap_ret),
  .trap_take      (trap_take),
  .flush          (flush),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .commit_valid   (commit_valid),
  .cause_q        (cause_q),
  .epc_q          (epc_q),
  .ie_q           (ie_q)
);

// File: tb/ptrap_ctrl_tb.sv
module ptrap_ctrl_tb;

  localparam int          PCW = 32;
  localparam logic [31:0] HPC = 32'h0000_0100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           if_valid, if_fault, id_illegal, ex_overflow, mem_fault, irq, trap_ret;
  logic [PCW-1:0] if_pc;
  logic           trap_take, flush, redirect_valid, commit_valid, ie_q;
  logic [PCW-1:0] redirect_pc, commit_pc, epc_q;
  logic [3:0]     cause_q;

  ptrap_ctrl #(.PCW(PCW), .HANDLER_PC(HPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc), .if_fault(if_fault),
    .id_illegal(id_illegal), .ex_overflow(ex_overflow), .mem_fault(mem_fault),
    .irq(irq), .trap_ret(trap_ret), .trap_take(trap_take), .flush(flush),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .commit_valid(commit_valid), .commit_pc(commit_pc),
    .cause_q(cause_q), .epc_q(epc_q), .ie_q(ie_q)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    bit          v;
    logic [31:0] pc;
    bit          fi, fd, fe, fm;
  } rec_t;

  rec_t        q[$];
  bit          ie_m      = 1'b1;
  logic [3:0]  cause_m   = 4'd0;
  logic [31:0] epc_m     = 32'd0;
  bit          last_trap = 1'b0;
  bit          last_irq  = 1'b0;
  logic [31:0] pc_ctr    = 32'h0000_1000;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pct(input int p);
    return (int'($urandom_range(99)) < p);
  endfunction

  task automatic step(input int pv, input int pf, input int pi, input int pr);
    rec_t        r;
    bit          m_v, sync, irq_t, trp, ret_t;
    logic [3:0]  sc;
    logic [31:0] e;
    @(negedge clk);
    r.v  = pct(pv);
    r.pc = pc_ctr;
    if (r.v) pc_ctr += 32'd4;
    r.fi = pct(pf); r.fd = pct(pf); r.fe = pct(pf); r.fm = pct(pf);
    q.push_front(r);
    if (q.size() > 4) void'(q.pop_back());
    if_valid    = r.v;
    if_pc       = r.pc;
    if_fault    = r.fi;
    id_illegal  = (q.size() > 1) ? q[1].fd : pct(50);
    ex_overflow = (q.size() > 2) ? q[2].fe : pct(50);
    mem_fault   = (q.size() > 3) ? q[3].fm : pct(50);
    irq         = pct(pi);
    trap_ret    = pct(pr);
    #1;
    // registered state from the previous decision
    chk(cause_q == cause_m, last_trap ? (last_irq ? "R3" : "R2") : "R10", "cause_q", 32'(cause_q), 32'(cause_m));
    chk(epc_q == epc_m, last_trap ? "R5" : "R10", "epc_q", epc_q, epc_m);
    chk(ie_q == ie_m, "R7", "ie_q", 32'(ie_q), 32'(ie_m));
    // this cycle's decision at commit
    m_v   = (q.size() == 4) && q[3].v;
    sync  = m_v && (q[3].fi || q[3].fd || q[3].fe || q[3].fm);
    sc    = 4'd4;
    if (m_v) begin
      if (q[3].fi)      sc = 4'd1;
      else if (q[3].fd) sc = 4'd2;
      else if (q[3].fe) sc = 4'd3;
    end
    irq_t = irq && ie_m;
    trp   = irq_t || sync;
    ret_t = trap_ret && !trp;
    chk(trap_take == trp, irq_t ? "R3" : (m_v ? "R1" : "R6"), "trap_take", 32'(trap_take), 32'(trp));
    chk(flush == (trp || ret_t), "R4", "flush", 32'(flush), 32'(trp || ret_t));
    chk(redirect_valid == (trp || ret_t), "R4", "redirect_valid", 32'(redirect_valid), 32'(trp || ret_t));
    if (trp)        chk(redirect_pc == HPC, "R4", "redirect_pc", redirect_pc, HPC);
    else if (ret_t) chk(redirect_pc == epc_m, "R7", "redirect_pc", redirect_pc, epc_m);
    chk(commit_valid == (m_v && !trp), "R8", "commit_valid", 32'(commit_valid), 32'(m_v && !trp));
    if (m_v && !trp) chk(commit_pc == q[3].pc, "R8", "commit_pc", commit_pc, q[3].pc);
    // advance the model
    last_trap = trp;
    last_irq  = irq_t;
    if (trp) begin
      cause_m = irq_t ? 4'd0 : sc;
      e = q[0].pc;
      for (int k = 0; k < q.size(); k++) if (q[k].v) e = q[k].pc;
      epc_m = e;
      ie_m  = 1'b0;
      q.delete();
    end else if (ret_t) begin
      ie_m = 1'b1;
      q.delete();
    end
  endtask

  initial begin
    #(150000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    if_valid = 1'b0; if_pc = '0; if_fault = 1'b0; id_illegal = 1'b0;
    ex_overflow = 1'b0; mem_fault = 1'b0; irq = 1'b0; trap_ret = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9: reset values
    chk(ie_q == 1'b1, "R9", "ie_q", 32'(ie_q), 32'd1);
    chk(cause_q == 4'd0, "R9", "cause_q", 32'(cause_q), 32'd0);
    chk(epc_q == '0, "R9", "epc_q", epc_q, 32'd0);
    chk(commit_valid == 1'b0, "R9", "commit_valid", 32'(commit_valid), 32'd0);
    chk(trap_take == 1'b0, "R9", "trap_take", 32'(trap_take), 32'd0);
    rst_n = 1'b1;
    // dense stream, rare events (R1, R8)
    for (int i = 0; i < 1500; i++) step(90, 3, 2, 5);
    // many faults per instruction (R2, R6)
    for (int i = 0; i < 1500; i++) step(70, 25, 1, 5);
    // sparse stream, frequent interrupts and returns (R3, R5, R7)
    for (int i = 0; i < 1500; i++) step(30, 5, 30, 20);
    // interrupts and returns colliding with faults (R3, R7, R10)
    for (int i = 0; i < 1500; i++) step(80, 10, 60, 40);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule